// File: doc/BRIEF.md
# Gamma Table Sequential Loader

This block fills the lookup memory used by a colour-correction curve. Every curve point stores a base value and a delta value for each of the red, green and blue channels. Software does not address individual table words. It sets a channel enable mask, writes a starting point number to the index register, and then streams every word through one data register. The loader works out which channel and which field each word lands in, and it moves to the next point by itself after every sixth word.

A programmable point limit bounds the load. A data write at or beyond that limit is dropped and raises a sticky overflow flag. A correction-enable register marks the table as live. While it is set, data writes are refused, so a curve in use cannot be torn. The curve evaluator reads all six values of one point combinationally through a separate read port.

Top module: `gamma_lut_loader`

## Requirements
- R1: After reset the load pointer and sub-slot are 0, the overflow flag and correction enable are 0, the channel mask is 3'b111, the point limit equals DEPTH, and every table word reads 0.
- R2: The register addresses are 0 for the channel mask, 1 for the index, 2 for data, 3 for the mode, 4 for the point limit and 5 for the overflow clear. A write to any other address changes no state.
- R3: The six data writes for one point go in this order: red base, green base, blue base, red delta, green delta, blue delta. The sub-slot output counts 0 to 5 in that order.
- R4: An accepted data write at sub-slot 5 returns the sub-slot to 0 and increments the load pointer by one. The pointer does not move on any other accepted data write.
- R5: In the mask, bit 0 is red, bit 1 is green and bit 2 is blue. A data write aimed at a channel whose bit is 0 leaves that table word unchanged, but the sub-slot still advances.
- R6: A write to the index register loads the pointer, clamped to DEPTH, and returns the sub-slot to 0 (red base).
- R7: A data write while the pointer is at or above the point limit changes neither the table, the pointer nor the sub-slot, and it sets the overflow flag. A write to the limit register clamps its value to DEPTH.
- R8: The overflow flag stays set until a write to the overflow-clear address.
- R9: Bit 0 of the mode register drives correction enable. While correction is enabled, data writes change neither the table, the pointer nor the sub-slot.
- R10: The read port returns, in the same cycle, the base and delta values of all three channels at the point selected by rdPoint. Red is in the low field, then green, then blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (3) | Register address |
| regWdata | input | VAL_W (16) | Register write data |
| rdPoint | input | IDX_W (5) | Point selected by the evaluator read port |
| rdBase | output | 3*VAL_W (48) | Base values of the selected point: {blue, green, red} |
| rdDelta | output | 3*VAL_W (48) | Delta values of the selected point: {blue, green, red} |
| loadPtr | output | IDX_W+1 (6) | Current load pointer |
| loadSlot | output | 3 | Current word slot within the point, 0 to 5 |
| ovfFlag | output | 1 | Sticky overflow flag |
| corrEnable | output | 1 | Correction enable from the mode register |

## Verification
The bench targets these corner cases:
- The wrap from slot 5 to the next point. A loader that wrapped one word early or late would put the deltas in the wrong fields and leave the pointer off by one.
- A masked channel. If its word were written, a zero entry would be clobbered. If the slot did not advance, all later words would be shifted by one.
- An index write issued in the middle of a point, which a faulty design would resume at a stale slot.
- Writes at the programmed limit and at the top entry of the table. These would either corrupt memory or lose the sticky flag.
- Data writes while correction is enabled, and writes to unused addresses. Both would alter the pointer or the table if they were not gated.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  localparam int NUM_CHAN   = 3;
  localparam int SLOT_COUNT = 2 * NUM_CHAN;

  // register addresses decoded by the control path
  localparam logic [2:0] ADR_MASK   = 3'd0;
  localparam logic [2:0] ADR_INDEX  = 3'd1;
  localparam logic [2:0] ADR_DATA   = 3'd2;
  localparam logic [2:0] ADR_MODE   = 3'd3;
  localparam logic [2:0] ADR_LIMIT  = 3'd4;
  localparam logic [2:0] ADR_OVFCLR = 3'd5;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic       isDelta;
    logic [1:0] chan;
  } store_strobe_t;

endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int VAL_W  = 16,
  parameter int ADDR_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [VAL_W-1:0]  regWdata,
  output store_strobe_t     strobe,
  output logic [IDX_W-1:0]  wrPoint,
  output logic [PTR_W-1:0]  loadPtr,
  output logic [2:0]        loadSlot,
  output logic [PTR_W-1:0]  ptrLimit,
  output logic              ovfFlag,
  output logic              corrEnable
);

  logic [NUM_CHAN-1:0] chanMask;
  logic wrMask, wrIndex, wrData, wrMode, wrLimit, wrOvfClr;
  logic dataLive, dataAccepted, dataOverflow;
  logic [1:0] chanSel;
  logic [PTR_W-1:0] clampedVal;

  always_comb begin
    wrMask   = regWe && (regAddr == ADDR_W'(ADR_MASK));
    wrIndex  = regWe && (regAddr == ADDR_W'(ADR_INDEX));
    wrData   = regWe && (regAddr == ADDR_W'(ADR_DATA));
    wrMode   = regWe && (regAddr == ADDR_W'(ADR_MODE));
    wrLimit  = regWe && (regAddr == ADDR_W'(ADR_LIMIT));
    wrOvfClr = regWe && (regAddr == ADDR_W'(ADR_OVFCLR));
  end

  always_comb begin
    if (regWdata > VAL_W'(DEPTH)) clampedVal = PTR_W'(DEPTH);
    else                          clampedVal = regWdata[PTR_W-1:0];
  end

  always_comb begin
    dataLive     = wrData && !corrEnable;
    dataAccepted = dataLive && (loadPtr < ptrLimit);
    dataOverflow = dataLive && (loadPtr >= ptrLimit);
    if (loadSlot < 3'd3) chanSel = loadSlot[1:0];
    else                 chanSel = 2'(loadSlot - 3'd3);
  end

  always_comb begin
    strobe.wrEn    = dataAccepted && chanMask[chanSel];
    strobe.isDelta = (loadSlot >= 3'd3);
    strobe.chan    = chanSel;
    wrPoint        = loadPtr[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanMask   <= '1;
      loadPtr    <= '0;
      loadSlot   <= '0;
      ptrLimit   <= PTR_W'(DEPTH);
      ovfFlag    <= 1'b0;
      corrEnable <= 1'b0;
    end else begin
      if (wrMask)  chanMask   <= regWdata[NUM_CHAN-1:0];
      if (wrMode)  corrEnable <= regWdata[0];
      if (wrLimit) ptrLimit   <= clampedVal;
      if (wrOvfClr)          ovfFlag <= 1'b0;
      else if (dataOverflow) ovfFlag <= 1'b1;
      if (wrIndex) begin
        loadPtr  <= clampedVal;
        loadSlot <= '0;
      end else if (dataAccepted) begin
        if (loadSlot == 3'(SLOT_COUNT - 1)) begin
          loadSlot <= '0;
          loadPtr  <= loadPtr + 1'b1;
        end else begin
          loadSlot <= loadSlot + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/gamma_lut_store.sv
module gamma_lut_store
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int VAL_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  store_strobe_t             strobe,
  input  logic [IDX_W-1:0]          wrPoint,
  input  logic [VAL_W-1:0]          wrValue,
  input  logic [IDX_W-1:0]          rdPoint,
  output logic [NUM_CHAN*VAL_W-1:0] rdBase,
  output logic [NUM_CHAN*VAL_W-1:0] rdDelta
);

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic [VAL_W-1:0] baseMem  [DEPTH];
    logic [VAL_W-1:0] deltaMem [DEPTH];
    logic hitChan;

    assign hitChan = strobe.wrEn && (strobe.chan == 2'(ch));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int p = 0; p < DEPTH; p++) begin
          baseMem[p]  <= '0;
          deltaMem[p] <= '0;
        end
      end else if (hitChan) begin
        if (strobe.isDelta) deltaMem[wrPoint] <= wrValue;
        else                baseMem[wrPoint]  <= wrValue;
      end
    end

    assign rdBase[ch*VAL_W +: VAL_W]  = baseMem[rdPoint];
    assign rdDelta[ch*VAL_W +: VAL_W] = deltaMem[rdPoint];
  end

endmodule

// File: rtl/gamma_lut_loader.sv
module gamma_lut_loader
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int VAL_W  = 16,
  parameter int ADDR_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWe,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [VAL_W-1:0]          regWdata,
  input  logic [IDX_W-1:0]          rdPoint,
  output logic [NUM_CHAN*VAL_W-1:0] rdBase,
  output logic [NUM_CHAN*VAL_W-1:0] rdDelta,
  output logic [PTR_W-1:0]          loadPtr,
  output logic [2:0]                loadSlot,
  output logic                      ovfFlag,
  output logic                      corrEnable
);

  store_strobe_t    strobe;
  logic [IDX_W-1:0] wrPoint;
  logic [PTR_W-1:0] ptrLimit;

  gamma_lut_ctrl #(.DEPTH(DEPTH), .VAL_W(VAL_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe), .wrPoint(wrPoint),
    .loadPtr(loadPtr), .loadSlot(loadSlot), .ptrLimit(ptrLimit),
    .ovfFlag(ovfFlag), .corrEnable(corrEnable)
  );

  gamma_lut_store #(.DEPTH(DEPTH), .VAL_W(VAL_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPoint(wrPoint),
    .wrValue(regWdata), .rdPoint(rdPoint), .rdBase(rdBase),
    .rdDelta(rdDelta)
  );

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int DEPTH  = 32,
  parameter int VAL_W  = 16,
  parameter int ADDR_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [VAL_W-1:0]  regWdata,
  input logic [PTR_W-1:0]  loadPtr,
  input logic [2:0]        loadSlot,
  input logic [PTR_W-1:0]  ptrLimit,
  input logic              ovfFlag,
  input logic              corrEnable
);

  logic dataWr;
  assign dataWr = regWe && (regAddr == ADDR_W'(2));

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadSlot <= 3'd5);

  // R4
  point_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && !corrEnable && (loadPtr < ptrLimit) && (loadSlot == 3'd5)
    |=> (loadSlot == 3'd0) && (loadPtr == $past(loadPtr) + 1'b1));

  // R6
  index_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe && (regAddr == ADDR_W'(1)) |=> loadSlot == 3'd0);

  // R7
  limit_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && !corrEnable && (loadPtr >= ptrLimit)
    |=> ovfFlag && $stable(loadPtr) && $stable(loadSlot));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(regWe && (regAddr == ADDR_W'(5))) |=> ovfFlag);

  // R9
  live_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && corrEnable |=> $stable(loadPtr) && $stable(loadSlot));

endmodule

bind gamma_lut_loader gamma_lut_chk #(.DEPTH(DEPTH), .VAL_W(VAL_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .loadPtr(loadPtr), .loadSlot(loadSlot),
  .ptrLimit(ptrLimit), .ovfFlag(ovfFlag), .corrEnable(corrEnable)
);

// File: tb/sim_gamma_lut_loader.sv
`timescale 1ns/1ps
module sim_gamma_lut_loader;

  localparam int DEPTH = 32;
  localparam int VAL_W = 16;
  localparam int ADDR_W = 3;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int NV = 14;

  // step vectors: address, data, expected pointer, slot, overflow
  localparam int VA[NV] = '{4, 1, 2, 2, 2, 2, 2, 2, 2, 2, 2, 2, 2, 2};
  localparam int VD[NV] = '{3, 0, 'h100, 'h101, 'h102, 'h103, 'h104, 'h105,
                            'h110, 'h111, 'h112, 'h113, 'h114, 'h115};
  localparam int VP[NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 2};
  localparam int VS[NV] = '{0, 0, 1, 2, 3, 4, 5, 0, 1, 2, 3, 4, 5, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [VAL_W-1:0] regWdata = '0;
  logic [IDX_W-1:0] rdPoint = '0;
  logic [3*VAL_W-1:0] rdBase, rdDelta;
  logic [PTR_W-1:0] loadPtr;
  logic [2:0] loadSlot;
  logic ovfFlag, corrEnable;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gamma_lut_loader #(.DEPTH(DEPTH), .VAL_W(VAL_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rdPoint(rdPoint), .rdBase(rdBase),
    .rdDelta(rdDelta), .loadPtr(loadPtr), .loadSlot(loadSlot),
    .ovfFlag(ovfFlag), .corrEnable(corrEnable)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    regWe = 1'b1;
    regAddr = ADDR_W'(a);
    regWdata = VAL_W'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic state(input string req, input int p, input int s, input int o);
    check(req, loadPtr, p);
    check(req, loadSlot, s);
    check(req, ovfFlag, o);
  endtask

  function automatic longint fld(input logic [3*VAL_W-1:0] v, input int ch);
    return longint'(v[ch*VAL_W +: VAL_W]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    state("R1", 0, 0, 0);
    check("R1", corrEnable, 0);
    check("R1", rdBase, 0);
    check("R1", rdDelta, 0);

    // R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VD[i]);
      state("R4", VP[i], VS[i], 0);
    end
    // R3 R10 word placement at point 0 and 1
    rdPoint = 0;
    #1;
    for (int c = 0; c < 3; c++) begin
      check("R3", fld(rdBase, c), 'h100 + c);
      check("R10", fld(rdDelta, c), 'h103 + c);
    end
    rdPoint = 1;
    #1;
    check("R3", fld(rdBase, 1), 'h111);
    check("R3", fld(rdDelta, 2), 'h115);

    // R5 green masked off at point 2
    wr(0, 5);
    for (int k = 0; k < 6; k++) wr(2, 'h200 + k);
    state("R5", 3, 0, 0);
    rdPoint = 2;
    #1;
    check("R5", fld(rdBase, 0), 'h200);
    check("R5", fld(rdBase, 1), 0);
    check("R5", fld(rdDelta, 1), 0);
    check("R5", fld(rdDelta, 2), 'h205);
    wr(0, 7);

    // R7 write at limit (3)
    wr(2, 'h333);
    state("R7", 3, 0, 1);
    rdPoint = 3;
    #1;
    check("R7", fld(rdBase, 0), 0);

    // R9 writes while correction live
    wr(3, 1);
    check("R9", corrEnable, 1);
    wr(1, 0);
    wr(2, 'h999);
    state("R9", 0, 0, 1);
    rdPoint = 0;
    #1;
    check("R9", fld(rdBase, 0), 'h100);
    wr(3, 0);
    check("R9", corrEnable, 0);

    // R6 index write mid-point
    wr(2, 'h500);
    wr(2, 'h501);
    check("R6", loadSlot, 2);
    wr(1, 1);
    state("R6", 1, 0, 1);
    wr(2, 'h600);
    rdPoint = 1;
    #1;
    check("R6", fld(rdBase, 0), 'h600);

    // R2 unused address leaves state alone
    wr(7, 'hFFFF);
    wr(6, 'hFFFF);
    state("R2", 1, 1, 1);
    check("R2", corrEnable, 0);

    // R8 sticky until cleared
    check("R8", ovfFlag, 1);
    wr(5, 0);
    check("R8", ovfFlag, 0);

    // R7 limit clamp and top entry
    wr(4, 'hFFFF);
    wr(1, 31);
    for (int k = 0; k < 6; k++) wr(2, 'h700 + k);
    state("R7", 32, 0, 0);
    rdPoint = 31;
    #1;
    check("R7", fld(rdDelta, 2), 'h705);
    wr(2, 'h800);
    state("R7", 32, 0, 1);
    // R6 index clamp
    wr(1, 'h50);
    check("R6", loadPtr, 32);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule